// File: doc/BRIEF.md
# Minicomputer Arithmetic/Logic Execute Stage

This block is the execute stage for the arithmetic/logic instruction class of a small 16-bit accumulator machine. Each instruction word picks a source and a destination from four accumulators. It applies one of eight basic functions, then settles the carry by XORing the arithmetic carry-out into a selectable base value. Next it rotates or byte-swaps the 17-bit carry-plus-result word, and last it evaluates a conditional skip on the final value. Every stage is steered directly by its own bit field. Nothing is decoded in between.

The stage registers its outputs, so results appear one clock after the operands are presented. The surrounding datapath writes `result_o` into the accumulator named by `dst_o` and `carry_o` into the carry flag whenever `wr_en_o` is high. It advances the program counter by two instead of one when `skip_o` is high. A no-load bit turns any instruction into a pure test: the write is suppressed, but the skip is still evaluated.

Top module: `alc_exec_unit`

## Requirements
- R1: While `rst_ni` is low, `result_o`, `carry_o`, `dst_o`, `wr_en_o` and `skip_o` are all zero.
- R2: Instruction fields are: source index [15:14], destination index [13:12], function [11:9], shift [8:7], carry select [6:5], no-load [4], skip [3:1]; bit 0 is ignored. Outputs reflect the instruction presented one clock earlier, and `dst_o` carries its destination index.
- R3: Function codes: 0 move (src), 1 complement (~src), 2 negate (0-src), 3 add (dst+src), 4 subtract (dst-src), 5 AND, 6 OR, 7 XOR; all results are modulo 2^16.
- R4: Carry-out is 1 for add when dst+src exceeds 16 bits, for subtract when dst >= src unsigned, for negate when src is 0, and 0 for the other functions. The new carry is this carry-out XORed into the selected base value.
- R5: Carry select codes: 0 current carry `carry_i`, 1 zero, 2 one, 3 inverted current carry.
- R6: Shift code 1 rotates the 17-bit {carry, result} left by one, and code 2 rotates it right by one. Code 0 leaves it unchanged.
- R7: Shift code 3 swaps the two result bytes and leaves the carry unchanged.
- R8: Skip codes test the shifted result and the new carry: 0 never, 1 always, 2 result zero, 3 result nonzero, 4 carry 1, 5 carry 0, 6 bit 15 set, 7 bit 15 clear.
- R9: When the no-load bit is 1, `wr_en_o` is 0, but `skip_o` is still evaluated.
- R10: When `exec_i` is low, `wr_en_o` and `skip_o` are 0 on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | An instruction is issued this cycle |
| instr_i | input | 16 | Instruction word |
| acc_i | input | 64 | Accumulators; accumulator k sits at bits [16k+15:16k] |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 16 | New destination value |
| carry_o | output | 1 | New carry value |
| dst_o | output | 2 | Destination accumulator index |
| wr_en_o | output | 1 | Write destination and carry |
| skip_o | output | 1 | Skip the next instruction |

## Verification
The embedded assertions take `instr_i`, `acc_i`, `carry_i` and `exec_i` to be stable and known at each rising edge. They also rely on `exec_i` being held low while reset is applied. The bench changes inputs one time unit after the rising edge and keeps `exec_i` low during reset. It sweeps all 32768 meaningful instruction words. Operands rotate through all-zero, all-one and sign-only accumulators and random values, so that zero, sign and carry-out conditions all occur.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int ALC_DATA_W = 16;
  localparam int ALC_ACC_N  = 4;
  localparam int ALC_ACC_W  = $clog2(ALC_ACC_N);

  typedef enum logic [2:0] {
    FN_MOV, FN_COM, FN_NEG, FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR
  } alc_fn_e;

  typedef enum logic [1:0] {CY_KEEP, CY_ZERO, CY_ONE, CY_FLIP} alc_cy_e;

  typedef enum logic [1:0] {SH_NONE, SH_LEFT, SH_RIGHT, SH_SWAP} alc_sh_e;

  typedef enum logic [2:0] {
    SK_NEVER, SK_ALWAYS, SK_ZERO, SK_NONZERO, SK_CY1, SK_CY0, SK_NEG, SK_POS
  } alc_sk_e;

  // field order fixes bit positions, MSB first
  typedef struct packed {
    logic [ALC_ACC_W-1:0] src;
    logic [ALC_ACC_W-1:0] dst;
    alc_fn_e              fn;
    alc_sh_e              sh;
    alc_cy_e              cy;
    logic                 no_load;
    alc_sk_e              sk;
    logic                 spare;
  } alc_instr_t;
endpackage

// File: rtl/alc_func_unit.sv
module alc_func_unit
  import alc_pkg::*;
#(
  parameter int DATA_W = ALC_DATA_W
) (
  input  alc_fn_e           fn_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cout_o
);
  logic [DATA_W-1:0] op_a, op_b, logic_res;
  logic              cin, arith;
  logic [DATA_W:0]   sum;

  // one shared adder: sub and neg use ~src with carry-in
  always_comb begin
    op_a  = '0;
    op_b  = '0;
    cin   = 1'b0;
    arith = 1'b0;
    unique case (fn_i)
      FN_ADD: begin op_a = dst_i; op_b = src_i;  arith = 1'b1; end
      FN_SUB: begin op_a = dst_i; op_b = ~src_i; cin = 1'b1; arith = 1'b1; end
      FN_NEG: begin op_a = '0;    op_b = ~src_i; cin = 1'b1; arith = 1'b1; end
      default: ;
    endcase
  end

  assign sum = {1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, cin};

  always_comb begin
    unique case (fn_i)
      FN_MOV:  logic_res = src_i;
      FN_COM:  logic_res = ~src_i;
      FN_AND:  logic_res = src_i & dst_i;
      FN_OR:   logic_res = src_i | dst_i;
      FN_XOR:  logic_res = src_i ^ dst_i;
      default: logic_res = '0;
    endcase
  end

  assign res_o  = arith ? sum[DATA_W-1:0] : logic_res;
  assign cout_o = arith & sum[DATA_W];
endmodule

// File: rtl/alc_shifter.sv
module alc_shifter
  import alc_pkg::*;
#(
  parameter int DATA_W = ALC_DATA_W
) (
  input  alc_sh_e           sh_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] swapped;

  generate
    if (DATA_W % 2 == 0) begin : g_even
      assign swapped = {res_i[HALF_W-1:0], res_i[DATA_W-1:HALF_W]};
    end else begin : g_odd
      assign swapped = res_i;
    end
  endgenerate

  always_comb begin
    unique case (sh_i)
      SH_LEFT:  {cy_o, res_o} = {res_i, cy_i};
      SH_RIGHT: {cy_o, res_o} = {res_i[0], cy_i, res_i[DATA_W-1:1]};
      SH_SWAP:  {cy_o, res_o} = {cy_i, swapped};
      default:  {cy_o, res_o} = {cy_i, res_i};
    endcase
  end
endmodule

// File: rtl/alc_skip_eval.sv
module alc_skip_eval
  import alc_pkg::*;
#(
  parameter int DATA_W = ALC_DATA_W
) (
  input  alc_sk_e           sk_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              cy_i,
  output logic              take_o
);
  logic is_zero, is_neg;

  assign is_zero = (res_i == '0);
  assign is_neg  = res_i[DATA_W-1];

  always_comb begin
    unique case (sk_i)
      SK_NEVER:   take_o = 1'b0;
      SK_ALWAYS:  take_o = 1'b1;
      SK_ZERO:    take_o = is_zero;
      SK_NONZERO: take_o = ~is_zero;
      SK_CY1:     take_o = cy_i;
      SK_CY0:     take_o = ~cy_i;
      SK_NEG:     take_o = is_neg;
      SK_POS:     take_o = ~is_neg;
      default:    take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alc_exec_unit.sv
module alc_exec_unit
  import alc_pkg::*;
#(
  parameter int DATA_W = ALC_DATA_W,
  parameter int ACC_N  = ALC_ACC_N,
  parameter int ACC_W  = $clog2(ACC_N)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    exec_i,
  input  logic [15:0]             instr_i,
  input  logic [ACC_N*DATA_W-1:0] acc_i,
  input  logic                    carry_i,
  output logic [DATA_W-1:0]       result_o,
  output logic                    carry_o,
  output logic [ACC_W-1:0]        dst_o,
  output logic                    wr_en_o,
  output logic                    skip_o
);
  alc_instr_t        ins;
  logic [DATA_W-1:0] acc_arr [ACC_N];
  logic [DATA_W-1:0] src_val, dst_val, fn_res, sh_res;
  logic              fn_cout, cy_base, cy_pre, sh_cy, take;
  logic              unused_spare;
  logic              armed_q;

  assign ins          = alc_instr_t'(instr_i);
  assign unused_spare = ins.spare;

  for (genvar k = 0; k < ACC_N; k++) begin : g_acc
    assign acc_arr[k] = acc_i[k*DATA_W +: DATA_W];
  end

  assign src_val = acc_arr[ins.src];
  assign dst_val = acc_arr[ins.dst];

  alc_func_unit #(.DATA_W(DATA_W)) u_fn (
    .fn_i  (ins.fn),
    .src_i (src_val),
    .dst_i (dst_val),
    .res_o (fn_res),
    .cout_o(fn_cout)
  );

  always_comb begin
    unique case (ins.cy)
      CY_ZERO: cy_base = 1'b0;
      CY_ONE:  cy_base = 1'b1;
      CY_FLIP: cy_base = ~carry_i;
      default: cy_base = carry_i;
    endcase
  end

  assign cy_pre = cy_base ^ fn_cout;

  alc_shifter #(.DATA_W(DATA_W)) u_sh (
    .sh_i (ins.sh),
    .res_i(fn_res),
    .cy_i (cy_pre),
    .res_o(sh_res),
    .cy_o (sh_cy)
  );

  alc_skip_eval #(.DATA_W(DATA_W)) u_sk (
    .sk_i  (ins.sk),
    .res_i (sh_res),
    .cy_i  (sh_cy),
    .take_o(take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      dst_o    <= '0;
      wr_en_o  <= 1'b0;
      skip_o   <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      result_o <= sh_res;
      carry_o  <= sh_cy;
      dst_o    <= ins.dst;
      wr_en_o  <= exec_i & ~ins.no_load;
      skip_o   <= exec_i & take;
      armed_q  <= 1'b1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |=>
    (result_o == '0 && !carry_o && dst_o == '0 && !wr_en_o && !skip_o));

  // R2
  dst_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(exec_i) |-> dst_o == $past(instr_i[13:12]));

  // R7
  swap_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(instr_i[8:7] == 2'd3 && instr_i[6:5] == 2'd0 && instr_i[11:9] >= 3'd5)
    |-> carry_o == $past(carry_i));

  // R8
  skip_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(exec_i && instr_i[3:1] == 3'd2) |-> skip_o == (result_o == '0));

  // R8
  skip_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(exec_i && instr_i[3:1] == 3'd6) |-> skip_o == result_o[DATA_W-1]);

  // R9
  no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(exec_i && instr_i[4]) |-> !wr_en_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(!exec_i) |-> !wr_en_o && !skip_o);
endmodule

// File: tb/tb_alc_exec_unit.sv
module tb_alc_exec_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        exec_i;
  logic [15:0] instr_i;
  logic [63:0] acc_i;
  logic        carry_i;
  logic [15:0] result_o;
  logic        carry_o;
  logic [1:0]  dst_o;
  logic        wr_en_o;
  logic        skip_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  alc_exec_unit dut (
    .clk_i, .rst_ni, .exec_i, .instr_i, .acc_i, .carry_i,
    .result_o, .carry_o, .dst_o, .wr_en_o, .skip_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h instr=%h", tag, act, exp, instr_i);
    end
  endtask

  function automatic logic [15:0] mk(input int s, input int d, input int fn, input int sh,
                                     input int cy, input int nl, input int sk);
    return {s[1:0], d[1:0], fn[2:0], sh[1:0], cy[1:0], nl[0], sk[2:0], 1'b0};
  endfunction

  // returns {skip, wr, carry, result}
  function automatic logic [18:0] model(input logic [15:0] ins, input logic [63:0] acc,
                                        input logic c, input logic ex);
    logic [15:0] s, d, r;
    logic [16:0] t;
    logic co, nc, tk;
    s = acc[ins[15:14]*16 +: 16];
    d = acc[ins[13:12]*16 +: 16];
    co = 1'b0;
    case (ins[11:9])
      3'd0: r = s;
      3'd1: r = ~s;
      3'd2: begin r = 16'd0 - s; co = (s == 16'd0); end
      3'd3: begin t = {1'b0, d} + {1'b0, s}; r = t[15:0]; co = t[16]; end
      3'd4: begin r = d - s; co = (d >= s); end
      3'd5: r = s & d;
      3'd6: r = s | d;
      default: r = s ^ d;
    endcase
    case (ins[6:5])
      2'd0: nc = c;
      2'd1: nc = 1'b0;
      2'd2: nc = 1'b1;
      default: nc = ~c;
    endcase
    nc = nc ^ co;
    case (ins[8:7])
      2'd1: begin t = {r, nc}; nc = t[16]; r = t[15:0]; end
      2'd2: begin t = {r[0], nc, r[15:1]}; nc = t[16]; r = t[15:0]; end
      2'd3: r = {r[7:0], r[15:8]};
      default: ;
    endcase
    case (ins[3:1])
      3'd0: tk = 1'b0;
      3'd1: tk = 1'b1;
      3'd2: tk = (r == 16'd0);
      3'd3: tk = (r != 16'd0);
      3'd4: tk = nc;
      3'd5: tk = ~nc;
      3'd6: tk = r[15];
      default: tk = ~r[15];
    endcase
    return {ex & tk, ex & ~ins[4], nc, r};
  endfunction

  task automatic apply(input logic [15:0] ins, input logic [63:0] acc, input logic c,
                       input logic ex);
    instr_i = ins;
    acc_i   = acc;
    carry_i = c;
    exec_i  = ex;
    @(posedge clk_i);
    #1;
  endtask

  task automatic run_full(input logic [15:0] ins, input logic [63:0] acc, input logic c);
    logic [18:0] e;
    e = model(ins, acc, c, 1'b1);
    apply(ins, acc, c, 1'b1);
    chk("R3 result", {16'd0, result_o}, {16'd0, e[15:0]});
    chk("R4 carry", {31'd0, carry_o}, {31'd0, e[16]});
    chk("R9 wr_en", {31'd0, wr_en_o}, {31'd0, e[17]});
    chk("R8 skip", {31'd0, skip_o}, {31'd0, e[18]});
    chk("R2 dst", {30'd0, dst_o}, {30'd0, ins[13:12]});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] acc;
    rst_ni  = 1'b0;
    exec_i  = 1'b0;
    instr_i = '0;
    acc_i   = '0;
    carry_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk("R1 reset", {13'd0, result_o, carry_o, dst_o, wr_en_o, skip_o}, 32'd0);
    rst_ni = 1'b1;

    // R3 add 7FFF+0001, keep carry 0 -> 8000, carry 0
    run_full(mk(1, 0, 3, 0, 0, 0, 6), {16'h0, 16'h0, 16'h0001, 16'h7FFF}, 1'b0);
    chk("R3 add", {16'd0, result_o}, 32'h8000);
    // R4 subtract equal values -> 0, carry 1
    run_full(mk(1, 0, 4, 0, 1, 0, 2), {16'h0, 16'h0, 16'h1234, 16'h1234}, 1'b0);
    chk("R4 sub carry", {31'd0, carry_o}, 32'd1);
    // R5 each carry source with move
    run_full(mk(0, 0, 0, 0, 0, 0, 0), 64'h5, 1'b1);
    chk("R5 keep", {31'd0, carry_o}, 32'd1);
    run_full(mk(0, 0, 0, 0, 1, 0, 0), 64'h5, 1'b1);
    chk("R5 zero", {31'd0, carry_o}, 32'd0);
    run_full(mk(0, 0, 0, 0, 2, 0, 0), 64'h5, 1'b0);
    chk("R5 one", {31'd0, carry_o}, 32'd1);
    run_full(mk(0, 0, 0, 0, 3, 0, 0), 64'h5, 1'b1);
    chk("R5 flip", {31'd0, carry_o}, 32'd0);
    // R6 rotate left 8000 carry 0 -> 0000 carry 1
    run_full(mk(0, 0, 0, 1, 0, 0, 0), 64'h8000, 1'b0);
    chk("R6 left", {15'd0, carry_o, result_o}, {15'd0, 1'b1, 16'h0000});
    // R6 rotate right 0001 carry 1 -> 8000 carry 1
    run_full(mk(0, 0, 0, 2, 0, 0, 0), 64'h0001, 1'b1);
    chk("R6 right", {15'd0, carry_o, result_o}, {15'd0, 1'b1, 16'h8000});
    // R7 swap 12AB carry 1 -> AB12 carry 1
    run_full(mk(0, 0, 0, 3, 0, 0, 0), 64'h12AB, 1'b1);
    chk("R7 swap", {15'd0, carry_o, result_o}, {15'd0, 1'b1, 16'hAB12});
    // R9 test-only: no write, skip still taken
    run_full(mk(0, 0, 0, 0, 0, 1, 1), 64'h0, 1'b0);
    chk("R9 test-only", {30'd0, wr_en_o, skip_o}, 32'd1);
    // R10 idle cycle with always-skip encoding
    apply(mk(0, 0, 0, 0, 0, 0, 1), 64'h0, 1'b0, 1'b0);
    chk("R10 idle", {30'd0, wr_en_o, skip_o}, 32'd0);

    // R2..R9 sweep of every instruction word
    for (int i = 0; i < 32768; i++) begin
      case (i % 8)
        0: acc = 64'h0;
        1: acc = {64{1'b1}};
        2: acc = {4{16'h8000}};
        3: acc = {16'h0001, 16'hFFFF, 16'h8000, 16'h0000};
        default: acc = {$urandom, $urandom};
      endcase
      run_full({i[14:0], 1'b0}, acc, 1'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule